// File: doc/BRIEF.md
# Coherent-Read Timer with Slow-Edge Start Control

A free-running 16-bit up-counter with a 24-bit wrap counter beside it. Software reaches it through a small byte-wide register port with eight addresses. A control byte holds four things: a run request, a mode bit that chooses immediate or slow-edge start/stop, a mode bit that chooses how multi-byte reads are captured, and a read-only flag that shows whether the counter is really counting.

Start and stop can take effect on the next fast clock, or wait for the first rising edge of a 32 kHz reference. That reference is brought into the fast domain through a two-stage synchronizer and a rising-edge detector. Reading a low byte takes a snapshot of the upper bytes, so a value read one byte at a time is coherent. Two event outputs each repeat one of six external timer events, chosen by a 3-bit code per output, as a single fast-clock pulse.

Register map (address: content):

- 0, control: [0] run request, [1] slow-edge mode, [2] running flag (read-only), [3] capture mode.
- 1, select: [2:0] counter select, [6:4] wrap select.
- 2, counter low byte.
- 3, counter high byte.
- 4, 5 and 6, wrap counter bytes 0, 1 and 2.
- 7, event routing: [2:0] code for output 0, [6:4] code for output 1.

Top module: `latched_timer`

## Requirements
- R1: After reset the control byte reads 0x02, so only the slow-edge mode bit is set. The select byte, the event routing byte and every counter byte read 0x00.
- R2: Control bit 0 reads back the last value written to it, whatever the real running state is.
- R3: With slow-edge mode 0, the running flag (control bit 2) takes the written run value one clock after the write. The counter then advances by one per clock while running and holds while stopped. A run of N clocks between the start write and the stop write adds exactly N.
- R4: With slow-edge mode 1, the running flag changes only on the third fast clock after a rising edge of slow_clk, after two synchronizer stages and one edge-detect stage. Falling edges of slow_clk do nothing.
- R5: The wrap counter increments in the same clock in which the counter passes from 0xFFFF to 0x0000.
- R6: With capture mode 0 and counter select 000, reading the low byte (address 2) captures the high byte. Later reads of address 3 return that captured byte until the next such capture. Before any capture, address 3 returns the live high byte.
- R7: With capture mode 0 and wrap select 000, reading wrap byte 0 returns it live and captures wrap bytes 1 and 2 for addresses 5 and 6.
- R8: With capture mode 1 and counter select 000, reading the low byte captures the high byte and all three wrap bytes in the same clock. Addresses 3 to 6 then return the captured copies.
- R9: With a nonzero counter select, addresses 2 and 3 read 0x00 and take no capture. With a nonzero wrap select, addresses 4 to 6 read 0x00 and take no capture.
- R10: Event code c from 0 to 5 routes input evt_src[c] to the selected output. The ordering is: period, compare 1, compare 2, wrap period, wrap compare 1, wrap compare 2. Each output is registered, so it pulses high for one clock, the clock after the input is high.
- R11: Event codes 110 and 111 never produce a pulse.
- R12: Reserved bits read as 0. These are bits 7:4 of the control byte, and bits 7 and 3 of both the select byte and the event routing byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | 32 kHz reference, asynchronous to clk |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe, one clock per read; captures happen on this clock |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, valid while bus_rd is high |
| evt_src | input | 6 | External timer events, one bit per event code 0 to 5 |
| evt_pulse | output | 2 | Routed event pulses, bit 0 for code [2:0] and bit 1 for code [6:4] |

## Verification
The counter is started and stopped over exactly counted windows of 300, 256 and 65,836 clocks. Because the end values are exact, these windows catch off-by-one errors in the start/stop pipeline and in the wrap carry. Between windows, bytes are read in both capture modes and with nonzero selects. A stale captured byte then differs from the live one, which shows whether a capture was taken, refreshed, or wrongly skipped. The slow-edge tests move the reference by hand: a rise, a fall and a second rise, with the running flag read just before and just after the expected clock. The event routes are tried for every code. Each code gets its own input alone, then all other inputs, then all inputs with the other output set to a reserved code, which separates wrong routing from a missing pulse.

// File: rtl/latched_timer.sv
module latched_timer #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16,
  parameter int WRAP_W      = 24,
  parameter int EVT_N       = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_clk,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [2:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [EVT_N-1:0] evt_src,
  output logic [1:0]       evt_pulse
);

  localparam logic [2:0] A_CTRL = 3'd0, A_SEL = 3'd1, A_CLO = 3'd2, A_CHI = 3'd3;
  localparam logic [2:0] A_W0 = 3'd4, A_W1 = 3'd5, A_W2 = 3'd6, A_EVT = 3'd7;
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic              run_q, slow_mode_q, cap_mode_q, running;
  logic [2:0]        csel_q, wsel_q, ev0_q, ev1_q;
  logic [CNT_W-1:0]  cnt;
  logic [WRAP_W-1:0] wrap, wrap_cap;
  logic [7:0]        hi_cap;
  logic              hi_vld, wrap_vld;
  logic [SYNC_STAGES:0] slow_sh;
  logic              slow_rise, cap_lo, cap_w0;

  assign slow_rise = slow_sh[SYNC_STAGES-1] & ~slow_sh[SYNC_STAGES];
  assign cap_lo    = bus_rd && bus_addr == A_CLO && csel_q == 3'd0;
  assign cap_w0    = bus_rd && bus_addr == A_W0 && wsel_q == 3'd0 && !cap_mode_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_q <= 1'b0; slow_mode_q <= 1'b1; cap_mode_q <= 1'b0;
      csel_q <= '0; wsel_q <= '0; ev0_q <= '0; ev1_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL: begin
          run_q       <= bus_wdata[0];
          slow_mode_q <= bus_wdata[1];
          cap_mode_q  <= bus_wdata[3];
        end
        A_SEL: begin csel_q <= bus_wdata[2:0]; wsel_q <= bus_wdata[6:4]; end
        A_EVT: begin ev0_q  <= bus_wdata[2:0]; ev1_q  <= bus_wdata[6:4]; end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) slow_sh <= '0;
    else        slow_sh <= {slow_sh[SYNC_STAGES-1:0], slow_clk};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) running <= 1'b0;
    else if (!slow_mode_q || slow_rise) running <= run_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; wrap <= '0;
    end else if (running) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_TOP) wrap <= wrap + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_cap <= '0; hi_vld <= 1'b0; wrap_cap <= '0; wrap_vld <= 1'b0;
    end else begin
      if (cap_lo) begin
        hi_cap <= cnt[15:8];
        hi_vld <= 1'b1;
      end
      if ((cap_lo && cap_mode_q) || cap_w0) begin
        wrap_cap <= wrap;
        wrap_vld <= 1'b1;
      end
    end

  logic [7:0] hi_rd, w0_rd, w1_rd, w2_rd;
  assign hi_rd = hi_vld ? hi_cap : cnt[15:8];
  assign w0_rd = (cap_mode_q && wrap_vld) ? wrap_cap[7:0] : wrap[7:0];
  assign w1_rd = wrap_vld ? wrap_cap[15:8]  : wrap[15:8];
  assign w2_rd = wrap_vld ? wrap_cap[23:16] : wrap[23:16];

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd)
      case (bus_addr)
        A_CTRL:  bus_rdata = {4'b0, cap_mode_q, running, slow_mode_q, run_q};
        A_SEL:   bus_rdata = {1'b0, wsel_q, 1'b0, csel_q};
        A_CLO:   bus_rdata = (csel_q == 3'd0) ? cnt[7:0] : 8'h00;
        A_CHI:   bus_rdata = (csel_q == 3'd0) ? hi_rd : 8'h00;
        A_W0:    bus_rdata = (wsel_q == 3'd0) ? w0_rd : 8'h00;
        A_W1:    bus_rdata = (wsel_q == 3'd0) ? w1_rd : 8'h00;
        A_W2:    bus_rdata = (wsel_q == 3'd0) ? w2_rd : 8'h00;
        default: bus_rdata = {1'b0, ev1_q, 1'b0, ev0_q};
      endcase
  end

  logic [7:0] src_ext;
  assign src_ext = 8'(evt_src);

  function automatic logic route(input logic [2:0] code, input logic [7:0] src);
    return (code < 3'd6) ? src[code] : 1'b0;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) evt_pulse <= '0;
    else        evt_pulse <= {route(ev1_q, src_ext), route(ev0_q, src_ext)};

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> $stable(cnt)); // R3
  AST_SLOW_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_mode_q && !slow_rise) |=> running == $past(running)); // R4
  AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt == CNT_TOP) |=> wrap == $past(wrap) + 1'b1); // R5
  AST_WRAP_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt != CNT_TOP) |=> $stable(wrap)); // R5
  AST_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_lo |=> $stable(hi_cap)); // R6
  AST_WRAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_lo && cap_mode_q) && !cap_w0 |=> $stable(wrap_cap)); // R8
  AST_EV0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev0_q[2:1] == 2'b11) |=> !evt_pulse[0]); // R11
  AST_EV1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev1_q[2:1] == 2'b11) |=> !evt_pulse[1]); // R11

endmodule

// File: tb/latched_timer_tb.sv
`timescale 1ns/1ps
module latched_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0, slow_clk = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [5:0] evt_src = '0;
  logic [1:0] evt_pulse;
  int checks = 0, errors = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sbq[$];

  always #4 clk = ~clk;

  latched_timer u_dut (.clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_src(evt_src), .evt_pulse(evt_pulse));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    item_t it;
    #3;
    if (bus_rd) begin
      if (sbq.size() == 0) check("scoreboard underrun", bus_rdata, 8'hxx);
      else begin
        it = sbq.pop_front();
        check(it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic evt(input logic [5:0] src, input logic [1:0] exp, input string tag);
    evt_src = src;
    @(negedge clk);
    evt_src = '0;
    #3 check(tag, {6'b0, evt_pulse}, {6'b0, exp});
    @(negedge clk);
    #3 check({tag, " width"}, {6'b0, evt_pulse}, 8'h00);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, 8'h02, "R1 ctrl reset");
    rd(3'd1, 8'h00, "R1 select reset");
    rd(3'd7, 8'h00, "R1 event reset");
    rd(3'd2, 8'h00, "R1 low reset");
    rd(3'd3, 8'h00, "R1 high reset");
    rd(3'd6, 8'h00, "R1 wrap2 reset");

    // capture mode 1, immediate start: snapshot wrap=0 first
    wr(3'd0, 8'h08);
    rd(3'd2, 8'h00, "R8 early capture");
    wr(3'd0, 8'h09);
    rd(3'd0, 8'h09, "R3 flag one clock late");
    rd(3'd0, 8'h0D, "R3 running flag");
    idle(65833);
    wr(3'd0, 8'h08);
    idle(2);
    rd(3'd4, 8'h00, "R8 stale wrap0");
    rd(3'd3, 8'h00, "R8 stale high");
    rd(3'd2, 8'h2C, "R3 count after 65836");
    rd(3'd3, 8'h01, "R3 high after 65836");
    rd(3'd4, 8'h01, "R5 wrap incremented");
    rd(3'd5, 8'h00, "R8 wrap1");
    rd(3'd6, 8'h00, "R8 wrap2");

    // capture mode 0
    wr(3'd0, 8'h00);
    rd(3'd4, 8'h01, "R7 wrap0 live");
    rd(3'd5, 8'h00, "R7 wrap1 captured");
    wr(3'd0, 8'h01);
    idle(299);
    wr(3'd0, 8'h00);
    idle(2);
    rd(3'd0, 8'h00, "R2 run readback");
    rd(3'd3, 8'h01, "R6 stale high");
    rd(3'd2, 8'h58, "R3 low after 300");
    rd(3'd3, 8'h02, "R6 refreshed high");

    // nonzero selects
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h01);
    idle(255);
    wr(3'd0, 8'h00);
    idle(2);
    rd(3'd2, 8'h00, "R9 low with select 1");
    rd(3'd3, 8'h00, "R9 high with select 1");
    wr(3'd1, 8'h10);
    rd(3'd4, 8'h00, "R9 wrap0 with select 1");
    wr(3'd1, 8'h00);
    rd(3'd3, 8'h02, "R9 no capture taken");
    rd(3'd2, 8'h58, "R9 low live");
    rd(3'd3, 8'h03, "R9 high after capture");

    // slow-edge start and stop
    wr(3'd0, 8'h03);
    idle(10);
    rd(3'd0, 8'h03, "R4 waits for edge");
    slow_clk = 1'b1;
    rd(3'd0, 8'h03, "R4 not yet");
    idle(1);
    rd(3'd0, 8'h03, "R4 third clock pending");
    rd(3'd0, 8'h07, "R4 started on edge");
    wr(3'd0, 8'h02);
    idle(3);
    rd(3'd0, 8'h06, "R2 run 0 while running");
    slow_clk = 1'b0;
    idle(5);
    rd(3'd0, 8'h06, "R4 falling edge ignored");
    slow_clk = 1'b1;
    idle(5);
    rd(3'd0, 8'h02, "R4 stopped on edge");

    // reserved bits
    wr(3'd0, 8'hF0);
    rd(3'd0, 8'h00, "R12 ctrl reserved");
    wr(3'd7, 8'hFF);
    rd(3'd7, 8'h77, "R12 event reserved");
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'h77, "R12 select reserved");
    wr(3'd1, 8'h00);

    // event routing
    for (int c = 0; c < 6; c++) begin
      wr(3'd7, {1'b0, 3'b111, 1'b0, 3'(c)});
      evt(6'(1 << c), 2'b01, "R10 route own input");
      evt(~6'(1 << c), 2'b00, "R10 other inputs");
      wr(3'd7, {1'b0, 3'(c), 1'b0, 3'b110});
      evt(6'h3F, 2'b10, "R11 reserved code quiet");
    end

    idle(2);
    check("scoreboard drained", 8'(sbq.size()), 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule